// File: doc/BRIEF.md
# Strip Readout Event Buffer

This block sits between a bank of strip ADCs and a readout bus. Each event is read from the front end as a series of beats. A beat carries one 12-bit sample from each of the parallel ADC channels. The block walks through the samples of each beat one at a time. For each sample it subtracts a per-strip pedestal held in an internal offset RAM, with the result floored at zero. It then discards any result that does not exceed a programmable threshold. Each surviving sample is packed with its strip address and an even-parity bit and written into an external single-port SRAM that is divided into event slots.

Several events can be held at once. A level-2 decision arrives for each buffered event in trigger order. A reject frees that event's slot at once. An accept queues the event for readout. Because any event can be dropped regardless of its age, the slots are managed individually rather than as a FIFO.

Accepted events leave over a valid/ready port. Each event starts with a header word that holds its stored-word count, followed by its words in strip order. The SRAM port always belongs to the digitization writer while an event is being filled. A readout in progress simply waits during that time.

Top module: `strip_event_buffer`

## Requirements
- R1: The stored value of a sample is the sample minus the offset RAM entry for its strip when the sample is larger than that entry, and 0 otherwise.
- R2: A sample is stored only when its corrected value is strictly greater than `zs_thr`. An event whose samples all fail this test is stored with a count of 0.
- R3: Channel c of a beat is taken from `adc_data[c*SW +: SW]`, and its strip address is beat*NCH + c. A stored word holds the strip address in the top SAW bits, the corrected value in bits [SW:1] and a parity bit in bit 0. The parity bit is chosen so that the XOR of all bits of the word is 0.
- R4: The buffer has NSLOT slots. `busy` is high while an event is being filled or when no slot is free. A `trig` pulse while `busy` is high is ignored and creates no event.
- R5: A `l2_valid` pulse applies to the oldest event still awaiting its decision. With `l2_accept`=0, that event's slot is freed in the same cycle, so `busy` drops if the buffer was full. A decision that arrives when no event is awaiting one has no effect.
- R6: Accepted events are read out in acceptance order. Each event starts with a header word holding the stored-word count, zero-extended, followed by the stored words in ascending strip order. `rd_last` marks the final word, which is the header itself when the count is 0.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_data`, `rd_last` and `rd_perr` hold their values.
- R8: The writer has sole use of the SRAM while an event is being filled. A readout that needs an SRAM word during a fill presents no `rd_valid` until the fill ends, then continues without losing or repeating words.
- R9: A word read back with odd overall parity sets `rd_perr`. The flag stays set for the rest of that event, readout continues unchanged, and the next header clears it.
- R10: Writing `cfg_data` to offset entry `cfg_addr` with `cfg_we` changes the offset used for that strip in every later event.
- R11: After reset all slots are free, `busy` is low and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Offset RAM write enable |
| cfg_addr | input | SAW | Offset RAM strip index |
| cfg_data | input | SW | Offset value to write |
| zs_thr | input | SW | Zero-suppression threshold |
| trig | input | 1 | Start-of-event trigger pulse |
| busy | output | 1 | High when a new trigger cannot be taken |
| adc_valid | input | 1 | One beat of samples is present |
| adc_data | input | NCH*SW | One sample per channel |
| l2_valid | input | 1 | Level-2 decision strobe |
| l2_accept | input | 1 | 1 = accept, 0 = reject |
| rd_valid | output | 1 | Readout word present |
| rd_ready | input | 1 | Bus takes the readout word |
| rd_data | output | WW | Header or stored word |
| rd_last | output | 1 | Final word of the event |
| rd_perr | output | 1 | Sticky parity error of the current event |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | RAW | SRAM address |
| sram_wdata | output | WW | SRAM write data |
| sram_rdata | input | WW | SRAM read data, one cycle after the address |

## Verification
The hardest situation to reach is a readout caught waiting for the SRAM at the moment a digitization takes the port. The bench sets this up by leaving an accepted event's header unacknowledged, raising a trigger, and only then acknowledging the header. The reader therefore asks for its first data word while the fill is running. The bench feeds the new event's beats and confirms that no word appears until the fill has finished. A parity fault is produced by watching the SRAM write port for the address of a chosen word and flipping one bit of it in the bench's SRAM model before that word is read back.

// File: rtl/strip_buf_pkg.sv
package strip_buf_pkg;
  typedef enum logic [2:0] {
    SLOT_FREE, SLOT_FILL, SLOT_WAIT, SLOT_ACC, SLOT_READ
  } slot_state_e;

  typedef enum logic [1:0] {
    RD_IDLE, RD_OUT, RD_ADDR, RD_WAIT
  } rd_state_e;
endpackage

// File: rtl/strip_offset_ram.sv
module strip_offset_ram #(
  parameter int SW    = 12,
  parameter int DEPTH = 1536,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [SW-1:0] rdata
);
  logic [SW-1:0] mem [DEPTH];

  // Plain synchronous RAM so that block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  assert_cfg_range_R10: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/strip_slot_fifo.sv
module strip_slot_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (int'(cnt) == DEPTH);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/strip_zs_writer.sv
module strip_zs_writer #(
  parameter int NCH    = 12,
  parameter int SW     = 12,
  parameter int NSTRIP = 1536,
  parameter int SAW    = $clog2(NSTRIP),
  parameter int CW     = $clog2(NSTRIP + 1),
  parameter int RAW    = 13,
  parameter int WW     = SAW + SW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SAW-1:0]    cfg_addr,
  input  logic [SW-1:0]     cfg_data,
  input  logic [SW-1:0]     zs_thr,
  input  logic              fill_active,
  input  logic [RAW-1:0]    fill_base,
  input  logic              adc_valid,
  input  logic [NCH*SW-1:0] adc_data,
  output logic              w_we,
  output logic [RAW-1:0]    w_addr,
  output logic [WW-1:0]     w_data,
  output logic              done,
  output logic [CW-1:0]     done_cnt
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  // beat capture and serializer
  logic [SW-1:0]  cap [NCH];
  logic           ser_act;
  logic [CHW-1:0] ch;
  logic [SAW-1:0] sidx;

  // stage A: sample and strip, offset read in flight
  logic           a_v;
  logic [SAW-1:0] a_strip;
  logic [SW-1:0]  a_samp;
  logic [SW-1:0]  off_q;

  // stage B: correction and suppression
  logic [SW-1:0]  corr;
  logic           keep;
  logic [CW-1:0]  wcnt;
  logic           b_last;

  strip_offset_ram #(.SW(SW), .DEPTH(NSTRIP), .AW(SAW)) u_off (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_data),
    .raddr (sidx),
    .rdata (off_q)
  );

  always_ff @(posedge clk) begin
    if (adc_valid && fill_active && !ser_act) begin
      for (int i = 0; i < NCH; i++) cap[i] <= adc_data[i*SW +: SW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_act <= 1'b0;
      ch      <= '0;
      sidx    <= '0;
      a_v     <= 1'b0;
      a_strip <= '0;
      a_samp  <= '0;
    end else begin
      a_v <= 1'b0;
      if (!fill_active) begin
        ser_act <= 1'b0;
        ch      <= '0;
        sidx    <= '0;
      end else if (ser_act) begin
        a_v     <= 1'b1;
        a_strip <= sidx;
        a_samp  <= cap[ch];
        sidx    <= sidx + 1'b1;
        if (ch == CHW'(NCH - 1)) begin
          ch      <= '0;
          ser_act <= 1'b0;
        end else begin
          ch <= ch + 1'b1;
        end
      end else if (adc_valid) begin
        ser_act <= 1'b1;
        ch      <= '0;
      end
    end
  end

  always_comb begin
    corr = (a_samp > off_q) ? (a_samp - off_q) : '0;
    keep = a_v && (corr > zs_thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_we   <= 1'b0;
      w_addr <= '0;
      w_data <= '0;
      b_last <= 1'b0;
      wcnt   <= '0;
    end else begin
      w_we   <= keep;
      w_addr <= fill_base + RAW'(wcnt);
      w_data <= {a_strip, corr, ^{a_strip, corr}};
      b_last <= a_v && (a_strip == SAW'(NSTRIP - 1));
      if (!fill_active) wcnt <= '0;
      else if (keep)    wcnt <= wcnt + 1'b1;
    end
  end

  assign done     = b_last;
  assign done_cnt = wcnt;

  assert_we_in_fill_R8: assert property (@(posedge clk) disable iff (rst)
    w_we |-> fill_active);
  assert_beat_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (adc_valid && fill_active) |-> !ser_act);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    int'(wcnt) <= NSTRIP);
endmodule

// File: rtl/strip_reader.sv
module strip_reader
  import strip_buf_pkg::*;
#(
  parameter int NSTRIP = 1536,
  parameter int NSLOT  = 4,
  parameter int SLW    = 2,
  parameter int CW     = 11,
  parameter int RAW    = 13,
  parameter int WW     = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           acc_empty,
  input  logic [SLW-1:0] acc_head,
  input  logic [CW-1:0]  head_cnt,
  output logic           acc_pop,
  input  logic           wr_busy,
  output logic           rd_issue,
  output logic [RAW-1:0] rd_addr,
  input  logic [WW-1:0]  sram_rdata,
  output logic           ev_done,
  output logic [SLW-1:0] rd_slot,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [WW-1:0]  rd_data,
  output logic           rd_last,
  output logic           rd_perr
);
  rd_state_e     st;
  logic [CW-1:0] cnt, idx;

  assign acc_pop  = (st == RD_IDLE) && !acc_empty;
  assign rd_issue = (st == RD_ADDR) && !wr_busy;
  assign ev_done  = (st == RD_OUT) && rd_ready && rd_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RD_IDLE;
      cnt      <= '0;
      idx      <= '0;
      rd_slot  <= '0;
      rd_addr  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_last  <= 1'b0;
      rd_perr  <= 1'b0;
    end else begin
      case (st)
        RD_IDLE: if (!acc_empty) begin
          rd_slot  <= acc_head;
          cnt      <= head_cnt;
          idx      <= '0;
          rd_data  <= WW'(head_cnt);
          rd_last  <= (head_cnt == '0);
          rd_perr  <= 1'b0;
          rd_valid <= 1'b1;
          st       <= RD_OUT;
        end
        RD_OUT: if (rd_ready) begin
          rd_valid <= 1'b0;
          if (rd_last) begin
            st <= RD_IDLE;
          end else begin
            rd_addr <= RAW'(rd_slot) * RAW'(NSTRIP) + RAW'(idx);
            st      <= RD_ADDR;
          end
        end
        RD_ADDR: if (!wr_busy) st <= RD_WAIT;
        RD_WAIT: begin
          rd_data  <= sram_rdata;
          rd_perr  <= rd_perr | (^sram_rdata);
          rd_last  <= ((idx + 1'b1) == cnt);
          idx      <= idx + 1'b1;
          rd_valid <= 1'b1;
          st       <= RD_OUT;
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last) && $stable(rd_perr)));
  assert_perr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_perr && st != RD_IDLE) |=> rd_perr);
  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (st != RD_IDLE) |-> (idx <= cnt));
endmodule

// File: rtl/strip_event_buffer.sv
module strip_event_buffer
  import strip_buf_pkg::*;
#(
  parameter int NCH    = 12,
  parameter int SW     = 12,
  parameter int NSTRIP = 1536,
  parameter int NSLOT  = 4,
  localparam int SAW   = $clog2(NSTRIP),
  localparam int WW    = SAW + SW + 1,
  localparam int RAW   = $clog2(NSLOT * NSTRIP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SAW-1:0]    cfg_addr,
  input  logic [SW-1:0]     cfg_data,
  input  logic [SW-1:0]     zs_thr,
  input  logic              trig,
  output logic              busy,
  input  logic              adc_valid,
  input  logic [NCH*SW-1:0] adc_data,
  input  logic              l2_valid,
  input  logic              l2_accept,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WW-1:0]     rd_data,
  output logic              rd_last,
  output logic              rd_perr,
  output logic              sram_we,
  output logic [RAW-1:0]    sram_addr,
  output logic [WW-1:0]     sram_wdata,
  input  logic [WW-1:0]     sram_rdata
);
  localparam int CW  = $clog2(NSTRIP + 1);
  localparam int SLW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  slot_state_e    slot_st  [NSLOT];
  logic [CW-1:0]  slot_cnt [NSLOT];
  logic           fill_active;
  logic [SLW-1:0] fill_slot;
  logic           free_any;
  logic [SLW-1:0] free_idx;
  logic           trig_take;

  logic           fill_done;
  logic [CW-1:0]  done_cnt;
  logic           w_we;
  logic [RAW-1:0] w_addr;
  logic [WW-1:0]  w_data;

  logic           wait_empty, wait_full, wait_pop;
  logic [SLW-1:0] wait_head;
  logic           acc_empty, acc_full, acc_push, acc_pop;
  logic [SLW-1:0] acc_head;

  logic           rd_issue, ev_done;
  logic [RAW-1:0] rd_addr;
  logic [SLW-1:0] rd_slot;
  logic [NSLOT-1:0] fill_vec;

  // lowest-numbered free slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_st[i] == SLOT_FREE) begin
        free_any = 1'b1;
        free_idx = SLW'(i);
      end
    end
  end

  assign busy      = fill_active || !free_any;
  assign trig_take = trig && !busy;
  assign wait_pop  = l2_valid && !wait_empty;
  assign acc_push  = wait_pop && l2_accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) begin
        slot_st[i]  <= SLOT_FREE;
        slot_cnt[i] <= '0;
      end
      fill_active <= 1'b0;
      fill_slot   <= '0;
    end else begin
      if (trig_take) begin
        slot_st[free_idx] <= SLOT_FILL;
        fill_active       <= 1'b1;
        fill_slot         <= free_idx;
      end
      if (fill_done) begin
        slot_st[fill_slot]  <= SLOT_WAIT;
        slot_cnt[fill_slot] <= done_cnt;
        fill_active         <= 1'b0;
      end
      if (wait_pop) slot_st[wait_head] <= l2_accept ? SLOT_ACC : SLOT_FREE;
      if (acc_pop)  slot_st[acc_head]  <= SLOT_READ;
      if (ev_done)  slot_st[rd_slot]   <= SLOT_FREE;
    end
  end

  strip_zs_writer #(
    .NCH(NCH), .SW(SW), .NSTRIP(NSTRIP), .SAW(SAW), .CW(CW), .RAW(RAW), .WW(WW)
  ) u_wr (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_data    (cfg_data),
    .zs_thr      (zs_thr),
    .fill_active (fill_active),
    .fill_base   (RAW'(fill_slot) * RAW'(NSTRIP)),
    .adc_valid   (adc_valid),
    .adc_data    (adc_data),
    .w_we        (w_we),
    .w_addr      (w_addr),
    .w_data      (w_data),
    .done        (fill_done),
    .done_cnt    (done_cnt)
  );

  // events awaiting their level-2 decision, in trigger order
  strip_slot_fifo #(.DEPTH(NSLOT), .W(SLW)) u_wait (
    .clk   (clk),
    .rst   (rst),
    .push  (fill_done),
    .din   (fill_slot),
    .pop   (wait_pop),
    .dout  (wait_head),
    .empty (wait_empty),
    .full  (wait_full)
  );

  // accepted events, in acceptance order
  strip_slot_fifo #(.DEPTH(NSLOT), .W(SLW)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .push  (acc_push),
    .din   (wait_head),
    .pop   (acc_pop),
    .dout  (acc_head),
    .empty (acc_empty),
    .full  (acc_full)
  );

  strip_reader #(
    .NSTRIP(NSTRIP), .NSLOT(NSLOT), .SLW(SLW), .CW(CW), .RAW(RAW), .WW(WW)
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .acc_empty  (acc_empty),
    .acc_head   (acc_head),
    .head_cnt   (slot_cnt[acc_head]),
    .acc_pop    (acc_pop),
    .wr_busy    (fill_active),
    .rd_issue   (rd_issue),
    .rd_addr    (rd_addr),
    .sram_rdata (sram_rdata),
    .ev_done    (ev_done),
    .rd_slot    (rd_slot),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .rd_last    (rd_last),
    .rd_perr    (rd_perr)
  );

  // single SRAM port: writer first
  assign sram_we    = w_we;
  assign sram_addr  = w_we ? w_addr : rd_addr;
  assign sram_wdata = w_data;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_fillvec
      assign fill_vec[g] = (slot_st[g] == SLOT_FILL);
    end
  endgenerate

  assert_port_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(w_we && rd_issue));
  assert_one_fill_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(fill_vec) <= 1);
  assert_full_ignores_trig_R4: assert property (@(posedge clk) disable iff (rst)
    (trig && !free_any && !fill_active) |=> !fill_active);
  assert_fill_flag_R4: assert property (@(posedge clk) disable iff (rst)
    fill_active |-> fill_vec[fill_slot]);
  assert_acc_room_R5: assert property (@(posedge clk) disable iff (rst)
    acc_push |-> !acc_full);
  assert_wait_room_R5: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> !wait_full);
endmodule

// File: tb/strip_event_buffer_test.sv
`timescale 1ns/1ps
module strip_event_buffer_test;
  localparam int NCH    = 4;
  localparam int SW     = 12;
  localparam int NSTRIP = 16;
  localparam int NSLOT  = 4;
  localparam int SAW    = $clog2(NSTRIP);
  localparam int WW     = SAW + SW + 1;
  localparam int RAW    = $clog2(NSLOT * NSTRIP);
  localparam int BEATS  = NSTRIP / NCH;
  localparam int THR    = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [SAW-1:0] cfg_addr = '0;
  logic [SW-1:0] cfg_data = '0;
  logic [SW-1:0] zs_thr = SW'(THR);
  logic trig = 1'b0;
  logic busy;
  logic adc_valid = 1'b0;
  logic [NCH*SW-1:0] adc_data = '0;
  logic l2_valid = 1'b0;
  logic l2_accept = 1'b0;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [WW-1:0] rd_data;
  logic rd_last;
  logic rd_perr;
  logic sram_we;
  logic [RAW-1:0] sram_addr;
  logic [WW-1:0] sram_wdata;
  logic [WW-1:0] sram_rdata;

  int checks = 0;
  int fails  = 0;
  bit ovr    = 1'b0;

  // bench SRAM model and monitors
  logic [WW-1:0] mem [NSLOT*NSTRIP];
  bit            snoop_en = 1'b0;
  logic [WW-1:0] tgt_word = '0;
  logic [RAW-1:0] tgt_addr = '0;
  bit            flip_req = 1'b0;
  bit            mon_en = 1'b0;
  int            stall_hits = 0;
  int            mon_writes = 0;

  always #2.5 clk = ~clk;

  strip_event_buffer #(.NCH(NCH), .SW(SW), .NSTRIP(NSTRIP), .NSLOT(NSLOT)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .zs_thr(zs_thr), .trig(trig), .busy(busy), .adc_valid(adc_valid), .adc_data(adc_data),
    .l2_valid(l2_valid), .l2_accept(l2_accept), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last), .rd_perr(rd_perr), .sram_we(sram_we),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  always @(posedge clk) begin
    if (sram_we) mem[sram_addr] <= sram_wdata;
    sram_rdata <= mem[sram_addr];
    if (snoop_en && sram_we && sram_wdata == tgt_word) tgt_addr <= sram_addr;
    if (flip_req) mem[tgt_addr] <= mem[tgt_addr] ^ WW'(2);
    if (mon_en && rd_valid) stall_hits++;
    if (mon_en && sram_we) mon_writes++;
  end

  function automatic int off_f(int s);
    if (ovr && s == 5) return 4095;
    return (s * 157) % 700;
  endfunction

  function automatic int smp_f(int ev, int s);
    if (ev == 99) return 0;
    if (ev == 7) return off_f(s) + THR + (s % 3) - 1;
    return (ev * 733 + s * 1291 + 17) % 4096;
  endfunction

  function automatic int corr_f(int ev, int s);
    int a = smp_f(ev, s);
    int o = off_f(s);
    return (a > o) ? a - o : 0;
  endfunction

  function automatic int word_f(int s, int c);
    logic [SAW-1:0] sa = SAW'(s);
    logic [SW-1:0]  cv = SW'(c);
    return int'({sa, cv, ^{sa, cv}});
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_offsets();
    for (int s = 0; s < NSTRIP; s++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = SAW'(s); cfg_data = SW'(off_f(s));
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic feed(input int ev, input bit mon);
    for (int b = 0; b < BEATS; b++) begin
      @(negedge clk);
      mon_en = mon;
      for (int c = 0; c < NCH; c++) adc_data[c*SW +: SW] = SW'(smp_f(ev, b * NCH + c));
      adc_valid = 1'b1;
      @(negedge clk);
      adc_valid = 1'b0;
      repeat (NCH + 2) @(negedge clk);
    end
    mon_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic l2(input bit acc);
    @(negedge clk); l2_valid = 1'b1; l2_accept = acc;
    @(negedge clk); l2_valid = 1'b0; l2_accept = 1'b0;
  endtask

  task automatic wait_valid(input string tag);
    int t = 0;
    while (!rd_valid && t < 3000) begin @(negedge clk); t++; end
    check(tag, int'(rd_valid), 1);
  endtask

  task automatic take(input string tag);
    logic [WW-1:0] d0 = rd_data;
    @(negedge clk);
    check({tag, " R7 hold valid"}, int'(rd_valid), 1);
    check({tag, " R7 hold data"}, int'(rd_data), int'(d0));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  // collect expected words of an event in strip order
  task automatic expect_words(input int ev, output int ew[NSTRIP], output int n);
    n = 0;
    for (int s = 0; s < NSTRIP; s++) begin
      int c = corr_f(ev, s);
      ew[s] = 0;
      if (c > THR) begin ew[n] = word_f(s, c); n++; end
    end
  endtask

  task automatic read_event(input int ev, input bit skip_hdr, input int cidx, input string tag);
    int ew[NSTRIP];
    int n;
    expect_words(ev, ew, n);
    if (!skip_hdr) begin
      wait_valid("R6 header present");
      check("R2 R6 header count", int'(rd_data), n);
      check("R6 header last", int'(rd_last), (n == 0) ? 1 : 0);
      check("R9 header perr cleared", int'(rd_perr), 0);
      take("header");
    end
    for (int k = 0; k < n; k++) begin
      int w = ew[k];
      if (k == cidx) w = w ^ 2;
      wait_valid("R6 word present");
      check(tag, int'(rd_data), w);
      check("R6 last flag", int'(rd_last), (k == n - 1) ? 1 : 0);
      check("R9 perr", int'(rd_perr), (cidx >= 0 && k >= cidx) ? 1 : 0);
      take("word");
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int ew[NSTRIP];
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 busy after reset", int'(busy), 0);
    check("R11 rd_valid after reset", int'(rd_valid), 0);

    load_offsets(); // R10 initial load

    // R1 R3: general pattern
    pulse_trig();
    check("R4 busy during fill", int'(busy), 1);
    feed(1, 1'b0);
    check("R4 busy after fill, slots free", int'(busy), 0);
    l2(1'b1);
    read_event(1, 1'b0, -1, "R1 R3 word");

    // R2 threshold boundary: corrected values thr-1, thr, thr+1
    pulse_trig(); feed(7, 1'b0); l2(1'b1);
    read_event(7, 1'b0, -1, "R2 boundary word");

    // R2 R6 empty event: header only
    pulse_trig(); feed(99, 1'b0); l2(1'b1);
    read_event(99, 1'b0, -1, "R6 empty");

    // R4 fill every slot
    for (int e = 10; e < 14; e++) begin pulse_trig(); feed(e, 1'b0); end
    check("R4 busy when full", int'(busy), 1);
    pulse_trig(); // ignored
    repeat (3) @(negedge clk);
    check("R4 busy after ignored trig", int'(busy), 1);
    // R5 decisions in trigger order
    l2(1'b0);
    check("R5 reject frees slot", int'(busy), 0);
    l2(1'b1); l2(1'b0); l2(1'b1);
    read_event(11, 1'b0, -1, "R5 R6 first accepted");
    read_event(13, 1'b0, -1, "R5 R6 second accepted");
    l2(1'b1); // nothing waiting
    repeat (60) @(negedge clk);
    check("R4 R5 no extra event", int'(rd_valid), 0);
    check("R5 slots all free", int'(busy), 0);

    // R8 readout caught by a new fill
    pulse_trig(); feed(20, 1'b0); l2(1'b1);
    wait_valid("R8 header ready");
    pulse_trig();
    expect_words(20, ew, n);
    check("R8 header count", int'(rd_data), n);
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    feed(21, 1'b1);
    check("R8 no word during fill", stall_hits, 0);
    check("R8 writer active in window", (mon_writes > 0) ? 1 : 0, 1);
    l2(1'b1);
    read_event(20, 1'b1, -1, "R8 resumed word");
    read_event(21, 1'b0, -1, "R8 next event word");

    // R10 rewrite one offset: strip 5 now always suppressed
    ovr = 1'b1;
    @(negedge clk); cfg_we = 1'b1; cfg_addr = SAW'(5); cfg_data = SW'(4095);
    @(negedge clk); cfg_we = 1'b0;
    pulse_trig(); feed(3, 1'b0); l2(1'b1);
    read_event(3, 1'b0, -1, "R10 word after offset rewrite");

    // R9 parity fault on word index 1
    expect_words(30, ew, n);
    tgt_word = WW'(ew[1]);
    snoop_en = 1'b1;
    pulse_trig(); feed(30, 1'b0);
    snoop_en = 1'b0;
    @(negedge clk); flip_req = 1'b1;
    @(negedge clk); flip_req = 1'b0;
    l2(1'b1);
    read_event(30, 1'b0, 1, "R9 word with fault");
    pulse_trig(); feed(31, 1'b0); l2(1'b1);
    read_event(31, 1'b0, -1, "R9 clean event");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule